// File: doc/BRIEF.md
# ATAPI Packet Phase Controller

This block follows a packet command through its phases on top of a byte-wide data port. A start pulse opens the command-out phase. The controller then gathers twelve bytes from the port into a command packet. It hands that packet to an external responder, which replies with an error, with "no data", or with a data length. When there is data, the controller measures it out in chunks. Each chunk is at most `MAX_CHUNK` bytes. The host reads each chunk through the data port, one access of 1, 2 or 4 bytes at a time.

At every point the controller presents three things. The first is the two-bit interrupt-reason value that the host sees in the sector-count register. The second is the chunk byte count that the host sees in the cylinder low and high registers. The third is the data-request flag. Every change of phase that the host must notice produces a one-cycle interrupt pulse, and so does every new chunk. Executing the command and moving data towards the device are the responder's job and lie outside this block.

Top module: `atapi_phase_ctrl`

## Requirements
- R1: A `pkt_start` pulse enters the command-out phase: `ireason` = 01 (bit 0 is command/data, bit 1 is direction-in), `drq` = 1, byte count 0, `abort_err` cleared. No `irq` is raised.
- R2: In command-out, twelve `wr_en` writes fill the packet, with the first byte in `req_packet[7:0]` and the twelfth in `req_packet[95:88]`. One cycle after the twelfth write is captured, `req_valid` pulses for one cycle. Writes made while the controller waits for the responder leave `req_packet` unchanged.
- R3: `req_len` is 10 when the first packet byte is 0x25, 0x28 or 0x5A, and 12 for any other opcode.
- R4: A response carrying a nonzero data length enters data-in: `ireason` = 10, `drq` = 1, byte count = min(length, `MAX_CHUNK`), and `irq` pulses.
- R5: A response with no data, or with length 0, enters completed: `ireason` = 11, `drq` = 0, byte count 0, and `irq` pulses.
- R6: A response with `resp_err` set enters completed with `abort_err` = 1, and `irq` pulses.
- R7: Each data-in read lowers the byte count by `rd_width` (never below 0) and adds `rd_width` to the bytes received.
- R8: When the byte count reaches 0 and fewer bytes have been received than the response length, a new chunk of min(remaining, `MAX_CHUNK`) bytes starts. `irq` pulses and the phase stays data-in.
- R9: When the byte count reaches 0 and all bytes have been received, the phase becomes completed (`ireason` = 11, `drq` = 0), and `irq` pulses.
- R10: Reads outside data-in change nothing and raise no `irq`.
- R11: After reset the controller is idle: `active` = 0, `ireason` = 00, `drq` = 0, `irq` = 0, byte count 0.
- R12: `pkt_start` in any phase, including the middle of data-in, restarts the command-out phase and clears the byte count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pkt_start | input | 1 | Packet command opcode received |
| wr_en | input | 1 | Data-port byte write |
| wr_byte | input | 8 | Written byte |
| rd_en | input | 1 | Data-port read |
| rd_width | input | 3 | Bytes taken by the read (1, 2 or 4) |
| req_valid | output | 1 | Packet ready for the responder (pulse) |
| req_opcode | output | 8 | First packet byte |
| req_len | output | 4 | Effective command length |
| req_packet | output | 96 | Collected packet, byte 0 lowest |
| resp_valid | input | 1 | Responder reply strobe |
| resp_has_data | input | 1 | Reply carries data-in |
| resp_len | input | LEN_W | Data-in length in bytes |
| resp_err | input | 1 | Responder failure |
| irq | output | 1 | Interrupt request pulse |
| active | output | 1 | A packet command is in progress |
| drq | output | 1 | Data request |
| abort_err | output | 1 | Abort error flag |
| ireason | output | 2 | Interrupt reason {direction-in, command/data} |
| bc_lo | output | 8 | Chunk byte count, low byte |
| bc_hi | output | 8 | Chunk byte count, high byte |

## Verification
The hardest case to reach is a chunk boundary that coincides with the end of data, or that falls in the middle of a read wider than the bytes left. With the default chunk limit, reaching it would take tens of thousands of reads. The bench therefore sets `MAX_CHUNK` to 16 and uses response lengths of 40, 16 and 5. These lengths produce a chunk refill, an exact final chunk, and a saturating 4-byte read over a 1-byte remainder. A restart issued in the middle of data-in covers the abandon path.

// File: rtl/atapi_phase_pkg.sv
package atapi_phase_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_CMD_OUT,
        PH_WAIT_RESP,
        PH_DATA_IN,
        PH_DONE
    } phase_e;

    localparam int          CDB_BYTES       = 12;
    localparam logic [7:0]  OP_RD_CAPACITY  = 8'h25;
    localparam logic [7:0]  OP_READ10       = 8'h28;
    localparam logic [7:0]  OP_MODE_SENSE10 = 8'h5A;

    typedef struct packed {
        phase_e phase;
        logic   irq;
        logic   req_valid;
        logic   abort;
    } ctrl_st_t;

    // Effective command length: 10-byte forms for three opcodes, else 12.
    function automatic logic [3:0] cdb_len(input logic [7:0] op);
        if (op == OP_RD_CAPACITY || op == OP_READ10 || op == OP_MODE_SENSE10)
            return 4'd10;
        return 4'd12;
    endfunction

endpackage

// File: rtl/atapi_cdb_collect.sv
module atapi_cdb_collect #(
    parameter int PKT_BYTES = 12
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   clear,
    input  logic                   wr_en,
    input  logic [7:0]             wr_byte,
    output logic                   full,
    output logic [PKT_BYTES*8-1:0] packet
);
    localparam int CNT_W = $clog2(PKT_BYTES + 1);

    typedef struct packed {
        logic [CNT_W-1:0]               count;
        logic [PKT_BYTES-1:0][7:0]      bytes;
    } col_st_t;

    col_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clear) begin
            st_d.count = '0;
        end else if (wr_en && (st_q.count < CNT_W'(PKT_BYTES))) begin
            st_d.bytes[st_q.count] = wr_byte;
            st_d.count             = st_q.count + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign full   = (st_q.count == CNT_W'(PKT_BYTES));
    assign packet = st_q.bytes;

    // R2: the fill level never passes the packet size
    a_r2_count_cap: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.count <= CNT_W'(PKT_BYTES));

endmodule

// File: rtl/atapi_chunk_seq.sv
module atapi_chunk_seq #(
    parameter int LEN_W     = 20,
    parameter int MAX_CHUNK = 32768
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  clear,
    input  logic                                  load,
    input  logic [LEN_W-1:0]                      load_len,
    input  logic                                  rd_en,
    input  logic [2:0]                            rd_width,
    output logic [$clog2(MAX_CHUNK+1)-1:0]        chunk,
    output logic                                  ev_more,
    output logic                                  ev_end
);
    localparam int CW = $clog2(MAX_CHUNK + 1);
    localparam int RW = LEN_W + 1;

    typedef struct packed {
        logic [LEN_W-1:0] total;
        logic [RW-1:0]    recv;
        logic [CW-1:0]    chunk;
    } seq_st_t;

    seq_st_t st_d, st_q;
    logic [31:0] left;
    logic [RW-1:0] recv_n;

    function automatic logic [CW-1:0] clamp_len(input logic [RW-1:0] x);
        if (32'(x) > MAX_CHUNK) return CW'(MAX_CHUNK);
        return CW'(x);
    endfunction

    always_comb begin
        st_d    = st_q;
        ev_more = 1'b0;
        ev_end  = 1'b0;
        left    = (32'(st_q.chunk) > 32'(rd_width)) ?
                  (32'(st_q.chunk) - 32'(rd_width)) : 32'd0;
        recv_n  = st_q.recv + RW'(rd_width);
        if (clear) begin
            st_d = '0;
        end else if (load) begin
            st_d.total = load_len;
            st_d.recv  = '0;
            st_d.chunk = clamp_len({1'b0, load_len});
        end else if (rd_en) begin
            st_d.recv = recv_n;
            if (left == 32'd0) begin
                if (recv_n < {1'b0, st_q.total}) begin
                    st_d.chunk = clamp_len({1'b0, st_q.total} - recv_n);
                    ev_more    = 1'b1;
                end else begin
                    st_d.chunk = '0;
                    ev_end     = 1'b1;
                end
            end else begin
                st_d.chunk = CW'(left);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign chunk = st_q.chunk;

    // R8: a published chunk never exceeds the limit
    a_r8_chunk_cap: assert property (@(posedge clk) disable iff (!rst_n)
        32'(st_q.chunk) <= MAX_CHUNK);

endmodule

// File: rtl/atapi_phase_ctrl.sv
module atapi_phase_ctrl
    import atapi_phase_pkg::*;
#(
    parameter int LEN_W     = 20,
    parameter int MAX_CHUNK = 32768
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pkt_start,
    input  logic              wr_en,
    input  logic [7:0]        wr_byte,
    input  logic              rd_en,
    input  logic [2:0]        rd_width,
    output logic              req_valid,
    output logic [7:0]        req_opcode,
    output logic [3:0]        req_len,
    output logic [95:0]       req_packet,
    input  logic              resp_valid,
    input  logic              resp_has_data,
    input  logic [LEN_W-1:0]  resp_len,
    input  logic              resp_err,
    output logic              irq,
    output logic              active,
    output logic              drq,
    output logic              abort_err,
    output logic [1:0]        ireason,
    output logic [7:0]        bc_lo,
    output logic [7:0]        bc_hi
);
    localparam int CW = $clog2(MAX_CHUNK + 1);

    ctrl_st_t st_d, st_q;

    logic          col_clear, col_wr, col_full;
    logic          seq_clear, seq_load, seq_rd, seq_more, seq_end;
    logic [CW-1:0] seq_chunk;
    logic [15:0]   bc16;

    always_comb begin
        st_d           = st_q;
        st_d.irq       = 1'b0;
        st_d.req_valid = 1'b0;
        col_clear      = 1'b0;
        seq_clear      = 1'b0;
        seq_load       = 1'b0;
        if (pkt_start) begin
            st_d.phase = PH_CMD_OUT;
            st_d.abort = 1'b0;
            col_clear  = 1'b1;
            seq_clear  = 1'b1;
        end else begin
            unique case (st_q.phase)
                PH_CMD_OUT: if (col_full) begin
                    st_d.phase     = PH_WAIT_RESP;
                    st_d.req_valid = 1'b1;
                    col_clear      = 1'b1;
                end
                PH_WAIT_RESP: if (resp_valid) begin
                    st_d.irq = 1'b1;
                    if (resp_err) begin
                        st_d.abort = 1'b1;
                        st_d.phase = PH_DONE;
                    end else if (resp_has_data && (resp_len != '0)) begin
                        st_d.phase = PH_DATA_IN;
                        seq_load   = 1'b1;
                    end else begin
                        st_d.phase = PH_DONE;
                    end
                end
                PH_DATA_IN: begin
                    if (seq_end) begin
                        st_d.phase = PH_DONE;
                        st_d.irq   = 1'b1;
                    end else if (seq_more) begin
                        st_d.irq   = 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '{phase: PH_IDLE, irq: 1'b0, req_valid: 1'b0, abort: 1'b0};
        else        st_q <= st_d;
    end

    assign col_wr = wr_en && !pkt_start && (st_q.phase == PH_CMD_OUT);
    assign seq_rd = rd_en && !pkt_start && (st_q.phase == PH_DATA_IN);

    atapi_cdb_collect #(.PKT_BYTES(CDB_BYTES)) u_collect (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (col_clear),
        .wr_en   (col_wr),
        .wr_byte (wr_byte),
        .full    (col_full),
        .packet  (req_packet)
    );

    atapi_chunk_seq #(.LEN_W(LEN_W), .MAX_CHUNK(MAX_CHUNK)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (seq_clear),
        .load     (seq_load),
        .load_len (resp_len),
        .rd_en    (seq_rd),
        .rd_width (rd_width),
        .chunk    (seq_chunk),
        .ev_more  (seq_more),
        .ev_end   (seq_end)
    );

    always_comb begin
        unique case (st_q.phase)
            PH_CMD_OUT, PH_WAIT_RESP: ireason = 2'b01;
            PH_DATA_IN:               ireason = 2'b10;
            PH_DONE:                  ireason = 2'b11;
            default:                  ireason = 2'b00;
        endcase
    end

    assign bc16       = 16'(seq_chunk);
    assign bc_lo      = bc16[7:0];
    assign bc_hi      = bc16[15:8];
    assign drq        = ((st_q.phase == PH_CMD_OUT) && !col_full) || (st_q.phase == PH_DATA_IN);
    assign active     = (st_q.phase != PH_IDLE);
    assign irq        = st_q.irq;
    assign abort_err  = st_q.abort;
    assign req_valid  = st_q.req_valid;
    assign req_opcode = req_packet[7:0];
    assign req_len    = cdb_len(req_opcode);

    // R4: while in data-in the sequencer always holds a live chunk
    a_r4_datain_chunk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.phase == PH_DATA_IN) |-> (seq_chunk != '0));
    // R6: the abort flag is only seen in the completed phase
    a_r6_abort_in_done: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.abort |-> (st_q.phase == PH_DONE));
    // R1: opening a packet command raises no interrupt
    a_r1_start_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_start |=> !irq);
    // R2: the packet hand-off is a single-cycle pulse
    a_r2_req_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> !req_valid);
    // R10: interrupts only accompany data-in or completion
    a_r10_irq_phase: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (st_q.phase == PH_DATA_IN || st_q.phase == PH_DONE));

endmodule

// File: tb/atapi_phase_ctrl_tb.sv
`timescale 1ns/1ps
module atapi_phase_ctrl_tb;
    localparam int MAXC = 16;
    localparam int LW   = 12;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pkt_start = 0, wr_en = 0, rd_en = 0;
    logic [7:0] wr_byte = 0;
    logic [2:0] rd_width = 0;
    logic resp_valid = 0, resp_has_data = 0, resp_err = 0;
    logic [LW-1:0] resp_len = 0;
    logic req_valid, irq, active, drq, abort_err;
    logic [7:0] req_opcode, bc_lo, bc_hi;
    logic [3:0] req_len;
    logic [95:0] req_packet;
    logic [1:0] ireason;

    int n_checks = 0;
    int n_fail   = 0;
    int m_total, m_recv, m_chunk;
    logic [19:0] expq[$];
    string tagq[$];

    always #2.5 clk = ~clk;

    atapi_phase_ctrl #(.LEN_W(LW), .MAX_CHUNK(MAXC)) u_dut (
        .clk(clk), .rst_n(rst_n), .pkt_start(pkt_start),
        .wr_en(wr_en), .wr_byte(wr_byte), .rd_en(rd_en), .rd_width(rd_width),
        .req_valid(req_valid), .req_opcode(req_opcode), .req_len(req_len),
        .req_packet(req_packet), .resp_valid(resp_valid),
        .resp_has_data(resp_has_data), .resp_len(resp_len), .resp_err(resp_err),
        .irq(irq), .active(active), .drq(drq), .abort_err(abort_err),
        .ireason(ireason), .bc_lo(bc_lo), .bc_hi(bc_hi)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    function automatic int clampc(input int x);
        return (x > MAXC) ? MAXC : x;
    endfunction

    // item = {ireason, byte count, abort, drq}
    task automatic push_exp(input string tag, input logic [1:0] ir, input int bc,
                            input logic ab, input logic dq);
        expq.push_back({ir, 16'(bc), ab, dq});
        tagq.push_back(tag);
    endtask

    // Scoreboard monitor: every interrupt pulse must match the next expected item
    always @(negedge clk) begin
        if (rst_n && irq) begin
            if (expq.size() == 0) begin
                chk("R10 unexpected irq", 32'(ireason), 32'hFFFF);
            end else begin
                logic [19:0] e;
                string t;
                e = expq.pop_front();
                t = tagq.pop_front();
                chk(t, {12'd0, ireason, bc_hi, bc_lo, abort_err, drq}, {12'd0, e});
            end
        end
    end

    task automatic do_start(input string tag);
        pkt_start = 1'b1;
        @(negedge clk);
        pkt_start = 1'b0;
        chk({tag, " ireason"}, 32'(ireason), 32'h1);
        chk({tag, " drq"}, 32'(drq), 32'h1);
        chk({tag, " bc"}, {16'd0, bc_hi, bc_lo}, 32'h0);
        chk({tag, " abort"}, 32'(abort_err), 32'h0);
        chk({tag, " irq"}, 32'(irq), 32'h0);
    endtask

    task automatic do_packet(input logic [7:0] op, input int exp_len);
        for (int i = 0; i < 12; i++) begin
            wr_en   = 1'b1;
            wr_byte = (i == 0) ? op : 8'(8'h40 + i);
            @(negedge clk);
        end
        wr_en = 1'b0;
        @(negedge clk);
        chk("R2 req_valid", 32'(req_valid), 32'h1);
        chk("R2 first byte", 32'(req_opcode), 32'(op));
        chk("R2 last byte", 32'(req_packet[95:88]), 32'h4B);
        chk("R3 req_len", 32'(req_len), 32'(exp_len));
    endtask

    task automatic do_resp(input logic err, input logic has, input int len);
        resp_valid = 1'b1; resp_err = err; resp_has_data = has; resp_len = LW'(len);
        if (err) push_exp("R6 abort", 2'b11, 0, 1'b1, 1'b0);
        else if (has && len != 0) begin
            m_total = len; m_recv = 0; m_chunk = clampc(len);
            push_exp("R4 data-in", 2'b10, m_chunk, 1'b0, 1'b1);
        end else push_exp("R5 no data", 2'b11, 0, 1'b0, 1'b0);
        @(negedge clk);
        resp_valid = 1'b0; resp_err = 0; resp_has_data = 0;
    endtask

    task automatic do_read(input int w);
        rd_en = 1'b1; rd_width = 3'(w);
        m_chunk = (m_chunk > w) ? m_chunk - w : 0;
        m_recv += w;
        if (m_chunk == 0) begin
            if (m_recv < m_total) begin
                m_chunk = clampc(m_total - m_recv);
                push_exp("R8 next chunk", 2'b10, m_chunk, 1'b0, 1'b1);
            end else push_exp("R9 completed", 2'b11, 0, 1'b0, 1'b0);
        end
        @(negedge clk);
        rd_en = 1'b0;
        chk("R7 byte count", {16'd0, bc_hi, bc_lo}, 32'(m_chunk));
    endtask

    task automatic read_ignored(input logic [1:0] ir);
        rd_en = 1'b1; rd_width = 3'd2;
        @(negedge clk);
        rd_en = 1'b0;
        @(negedge clk);
        chk("R10 bc unchanged", {16'd0, bc_hi, bc_lo}, 32'h0);
        chk("R10 phase unchanged", 32'(ireason), 32'(ir));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        chk("R11 active", 32'(active), 32'h0);
        chk("R11 ireason", 32'(ireason), 32'h0);
        chk("R11 drq", 32'(drq), 32'h0);
        chk("R11 irq", 32'(irq), 32'h0);
        chk("R11 bc", {16'd0, bc_hi, bc_lo}, 32'h0);
        read_ignored(2'b00);

        // Chunked data-in with refill
        do_start("R1 start");
        do_packet(8'h28, 10);
        wr_en = 1'b1; wr_byte = 8'hEE;
        @(negedge clk);
        wr_en = 1'b0;
        chk("R2 write while waiting", 32'(req_packet[7:0]), 32'h28);
        do_resp(1'b0, 1'b1, 40);
        chk("R4 drq", 32'(drq), 32'h1);
        while (m_recv < m_total) do_read(2);
        chk("R9 drq low", 32'(drq), 32'h0);
        read_ignored(2'b11);

        // No data
        do_start("R1 start 2");
        do_packet(8'h12, 12);
        do_resp(1'b0, 1'b0, 0);
        chk("R5 ireason", 32'(ireason), 32'h3);

        // Error, then abort cleared by next start
        do_start("R1 start 3");
        do_packet(8'h5A, 10);
        do_resp(1'b1, 1'b0, 0);
        chk("R6 abort flag", 32'(abort_err), 32'h1);
        do_start("R1 abort cleared");
        do_packet(8'h25, 10);
        do_resp(1'b0, 1'b1, 5);
        do_read(4);
        do_read(4);
        chk("R9 after saturating read", 32'(ireason), 32'h3);

        // Zero length counts as no data
        do_start("R1 start 5");
        do_packet(8'h00, 12);
        do_resp(1'b0, 1'b1, 0);

        // Exact-limit chunk, restart mid data-in
        do_start("R1 start 6");
        do_packet(8'hBE, 12);
        do_resp(1'b0, 1'b1, 16);
        do_read(4); do_read(4); do_read(4);
        do_start("R12 restart");
        repeat (2) @(negedge clk);
        chk("R12 queue drained", 32'(expq.size()), 32'h0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule